// File: doc/BRIEF.md
# Packed Fixed-Point Multiply Unit

This block is a lane-parallel multiplier for 128-bit vectors. Each 16-bit lane works alone and has two modes. In the byte multiply-accumulate mode, the lane multiplies the two bytes of operand A, taken as unsigned, by the matching two bytes of operand B, taken as signed. It adds the two products and clamps the sum to the signed 16-bit range. In the rounding multiply mode, the lane multiplies two signed 16-bit values and returns a rounded, scaled 16-bit fraction in Q15 style.

An issuing pipeline presents both operands, a one-bit mode and a valid strobe in the same cycle. Stage 1 registers the products. Stage 2 registers the sum-and-clamp result or the round result. The result and its valid flag come out exactly two clocks after issue. A new operation may be issued on every cycle, and the mode may change from one cycle to the next.

Top module: `vec_fixmul_unit`

## Requirements
- R1: With `op_mode` = 0 (byte multiply-accumulate), every byte of `opa` is read as unsigned (0..255) and every byte of `opb` is read as signed (-128..127).
- R2: In byte mode, result lane k (bits [16k+15:16k]) equals opa byte 2k times opb byte 2k, plus opa byte 2k+1 times opb byte 2k+1, where byte n is bits [8n+7:8n]. The eight lanes are independent.
- R3: In byte mode, a pairwise sum above 32767 gives 0x7FFF, and a sum below -32768 gives 0x8000.
- R4: With `op_mode` = 1 (rounding multiply), lane k forms the signed 32-bit product P of the two 16-bit lanes. The lane then computes T = (P arithmetically shifted right by 14) + 1, and the result is bits [16:1] of T.
- R5: In rounding mode, 0x8000 times 0x8000 gives 0x8000 (it wraps and is not saturated).
- R6: `res_valid` equals `in_valid` delayed by exactly two rising clock edges.
- R7: While `rst` is high at a rising edge, both pipeline valid bits and `res_data` clear to zero. An operation in flight when reset arrives never shows up as a result.
- R8: `res_data` changes only in a cycle in which `res_valid` is high. Between valid results it holds its last value, whatever the inputs do.
- R9: The mode is captured together with its operands, so operations of mixed modes issued back to back each produce their own mode's result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| op_mode | input | 1 | 0 = byte multiply-accumulate, 1 = rounding multiply |
| opa | input | 128 | Operand A |
| opb | input | 128 | Operand B |
| res_valid | output | 1 | Result valid, two cycles after issue |
| res_data | output | 128 | Eight 16-bit lane results |

## Verification
The hardest conditions to reach from the ports are the exact edges of each lane's arithmetic: the two clamp bounds of the pairwise sum and the single wrapping operand pair of the rounding mode. Uniform random operands almost never produce these. The stimulus therefore drives directed extreme byte patterns into chosen lanes and mixes them with random lanes in the same vector. Back-to-back issues alternate the mode every cycle, and a reset lands while operations are still in both stages, so that capture of the mode and flushing of the pipeline are both tested.

// File: rtl/vfm_pkg.sv
package vfm_pkg;
  typedef enum logic {
    MODE_BYTE_MAC  = 1'b0,
    MODE_ROUND_MUL = 1'b1
  } vfm_mode_e;
endpackage

// File: rtl/vfm_lane.sv
module vfm_lane #(
  parameter int LANE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap1,
  input  logic              cap2,
  input  logic              mode_in,
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  output logic [LANE_W-1:0] res
);
  import vfm_pkg::*;

  localparam int HB  = LANE_W / 2;       // byte width
  localparam int PBW = LANE_W + 1;       // unsigned x signed byte product
  localparam int PW  = 2 * LANE_W;       // full word product
  localparam int SW  = LANE_W + 2;       // pairwise sum width
  localparam int SH  = LANE_W - 2;       // keep top bits of product

  // stage 1 state
  logic signed [PBW-1:0] prod_lo_q, prod_hi_q;
  logic signed [PW-1:0]  prod_w_q;
  vfm_mode_e             mode_q;

  logic signed [PBW-1:0] prod_lo_d, prod_hi_d;
  logic signed [PW-1:0]  prod_w_d;

  always_comb begin
    prod_lo_d = $signed({{(PBW-HB){1'b0}}, a[HB-1:0]}) *
                $signed({{(PBW-HB){b[HB-1]}}, b[HB-1:0]});
    prod_hi_d = $signed({{(PBW-HB){1'b0}}, a[LANE_W-1:HB]}) *
                $signed({{(PBW-HB){b[LANE_W-1]}}, b[LANE_W-1:HB]});
    prod_w_d  = $signed({{(PW-LANE_W){a[LANE_W-1]}}, a}) *
                $signed({{(PW-LANE_W){b[LANE_W-1]}}, b});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_lo_q <= '0;
      prod_hi_q <= '0;
      prod_w_q  <= '0;
      mode_q    <= MODE_BYTE_MAC;
    end else if (cap1) begin
      prod_lo_q <= prod_lo_d;
      prod_hi_q <= prod_hi_d;
      prod_w_q  <= prod_w_d;
      mode_q    <= vfm_mode_e'(mode_in);
    end
  end

  // stage 2: pairwise saturating add, or shift-increment round
  logic signed [SW-1:0] pair_sum;
  logic [LANE_W-1:0]    mac_val;
  logic signed [PW-1:0] rnd_tmp;
  logic [LANE_W-1:0]    rnd_val;
  logic                 sum_ovf;

  always_comb begin
    pair_sum = {{(SW-PBW){prod_lo_q[PBW-1]}}, prod_lo_q} +
               {{(SW-PBW){prod_hi_q[PBW-1]}}, prod_hi_q};
    // overflow when the bits above the result sign disagree
    sum_ovf  = (pair_sum[SW-1:LANE_W-1] != {(SW-LANE_W+1){1'b0}}) &&
               (pair_sum[SW-1:LANE_W-1] != {(SW-LANE_W+1){1'b1}});
    if (!sum_ovf)
      mac_val = pair_sum[LANE_W-1:0];
    else if (pair_sum[SW-1])
      mac_val = {1'b1, {(LANE_W-1){1'b0}}};
    else
      mac_val = {1'b0, {(LANE_W-1){1'b1}}};
    rnd_tmp = (prod_w_q >>> SH) + PW'(1);
    rnd_val = rnd_tmp[LANE_W:1];
  end

  always_ff @(posedge clk) begin
    if (rst)
      res <= '0;
    else if (cap2)
      res <= (mode_q == MODE_ROUND_MUL) ? rnd_val : mac_val;
  end
endmodule

// File: rtl/vec_fixmul_unit.sv
module vec_fixmul_unit #(
  parameter int VEC_W  = 128,
  parameter int LANE_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             op_mode,
  input  logic [VEC_W-1:0] opa,
  input  logic [VEC_W-1:0] opb,
  output logic             res_valid,
  output logic [VEC_W-1:0] res_data
);
  localparam int LANES = VEC_W / LANE_W;

  logic stg1_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg1_vld  <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      stg1_vld  <= in_valid;
      res_valid <= stg1_vld;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    vfm_lane #(.LANE_W(LANE_W)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .cap1   (in_valid),
      .cap2   (stg1_vld),
      .mode_in(op_mode),
      .a      (opa[k*LANE_W +: LANE_W]),
      .b      (opb[k*LANE_W +: LANE_W]),
      .res    (res_data[k*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/vfm_checker.sv
module vfm_checker #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             op_mode,
  input logic [VEC_W-1:0] opa,
  input logic [VEC_W-1:0] opb,
  input logic             res_valid,
  input logic [VEC_W-1:0] res_data
);
  // R6
  latency_two_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (res_valid == $past(in_valid, 2)));

  // R7
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!res_valid && res_data == '0));

  // R8
  hold_data_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !res_valid) |-> $stable(res_data));

  // R5
  wrap_corner_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_mode && opa[15:0] == 16'h8000 && opb[15:0] == 16'h8000)
      |=> ##1 (res_valid && res_data[15:0] == 16'h8000));

  // R3
  sat_high_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !op_mode && opa[15:0] == 16'hFFFF && opb[15:0] == 16'h7F7F)
      |=> ##1 (res_valid && res_data[15:0] == 16'h7FFF));
endmodule

bind vec_fixmul_unit vfm_checker #(.VEC_W(VEC_W)) u_vfm_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .op_mode  (op_mode),
  .opa      (opa),
  .opb      (opb),
  .res_valid(res_valid),
  .res_data (res_data)
);

// File: tb/sim_vec_fixmul_unit.sv
module sim_vec_fixmul_unit;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic         op_mode;
  logic [127:0] opa, opb;
  logic         res_valid;
  logic [127:0] res_data;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  bit    done = 0;
  string tag = "R7";

  // behavioural model state
  bit           m1_v = 0, mo_v = 0;
  logic [127:0] m1_r = '0, mo_r = '0;

  vec_fixmul_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_mode(op_mode),
    .opa(opa), .opb(opb), .res_valid(res_valid), .res_data(res_data)
  );

  always #5 clk = ~clk;

  function automatic logic [127:0] model(input logic md, input logic [127:0] a,
                                         input logic [127:0] b);
    logic [127:0] r;
    for (int k = 0; k < 8; k++) begin
      if (!md) begin
        int s = 0;
        for (int j = 0; j < 2; j++) begin
          int ua = int'(a[16*k+8*j +: 8]);
          int sb = int'($signed(b[16*k+8*j +: 8]));
          s += ua * sb;
        end
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        r[16*k +: 16] = 16'(s);
      end else begin
        longint p = longint'($signed(a[16*k +: 16])) * longint'($signed(b[16*k +: 16]));
        longint t = (p >>> 14) + 1;
        r[16*k +: 16] = 16'(t >>> 1);
      end
    end
    return r;
  endfunction

  task automatic compare();
    checks++;
    if (res_valid !== mo_v || res_data !== mo_r) begin
      errors++;
      $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h",
               tag, res_valid, res_data, mo_v, mo_r);
    end
  endtask

  task automatic cyc(input bit r, input bit v, input bit md,
                     input logic [127:0] a, input logic [127:0] b);
    @(negedge clk);
    compare();
    rst = r; in_valid = v; op_mode = md; opa = a; opb = b;
    if (r) begin
      m1_v = 0; mo_v = 0; m1_r = '0; mo_r = '0;
    end else begin
      mo_v = m1_v;
      if (m1_v) mo_r = m1_r;
      m1_v = v;
      if (v) m1_r = model(md, a, b);
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic drain();
    for (int i = 0; i < 3; i++) cyc(0, 0, $urandom_range(0, 1), rnd128(), rnd128());
  endtask

  initial begin
    rst = 1; in_valid = 0; op_mode = 0; opa = '0; opb = '0;
    // R7: reset state
    tag = "R7";
    for (int i = 0; i < 3; i++) cyc(1, 1, 0, rnd128(), rnd128());
    // R1 R2: unsigned A bytes, signed B bytes, distinct per lane
    tag = "R1";
    cyc(0, 1, 0, {16{8'hC8}}, {16{8'hFE}});
    cyc(0, 1, 0, 128'h0807_0605_0403_0201_8081_7F01_1020_3040,
                 128'h0102_0304_0506_0708_01FF_FF01_F010_E020);
    tag = "R2";
    for (int i = 0; i < 20; i++) cyc(0, 1, 0, rnd128(), rnd128());
    drain();
    // R3: saturation at both bounds, mixed with random lanes
    tag = "R3";
    cyc(0, 1, 0, {{6{16'h1234}}, 16'hFFFF, 16'hFFFF}, {{6{16'h5678}}, 16'h8080, 16'h7F7F});
    cyc(0, 1, 0, {rnd128()} | {{7{16'h0}}, 16'hFFFF}, {rnd128()} & ~128'hFFFF | 128'h7F7F);
    cyc(0, 1, 0, {8{16'hFF80}}, {8{16'h8080}});
    cyc(0, 1, 0, {8{16'hFFFF}}, {{4{16'h7F80}}, {4{16'h807F}}});
    drain();
    // R4: rounding multiply
    tag = "R4";
    cyc(0, 1, 1, {8{16'h4000}}, {16'h4000, 16'hC000, 16'h0001, 16'hFFFF,
                                 16'h7FFF, 16'h8001, 16'h0002, 16'h3FFF});
    for (int i = 0; i < 20; i++) cyc(0, 1, 1, rnd128(), rnd128());
    drain();
    // R5: wrap corner
    tag = "R5";
    cyc(0, 1, 1, {8{16'h8000}}, {8{16'h8000}});
    cyc(0, 1, 1, {rnd128()} & ~128'hFFFF | 128'h8000, {rnd128()} & ~128'hFFFF | 128'h8000);
    drain();
    // R9: alternating modes back to back
    tag = "R9";
    for (int i = 0; i < 30; i++) cyc(0, 1, i[0], rnd128(), rnd128());
    drain();
    // R6 R8: sparse valid with changing idle inputs
    tag = "R6";
    for (int i = 0; i < 60; i++)
      cyc(0, ($urandom_range(0, 2) == 0), $urandom_range(0, 1), rnd128(), rnd128());
    tag = "R8";
    cyc(0, 1, 0, rnd128(), rnd128());
    for (int i = 0; i < 10; i++) cyc(0, 0, $urandom_range(0, 1), rnd128(), rnd128());
    // R7: reset with both stages full
    tag = "R7";
    cyc(0, 1, 1, rnd128(), rnd128());
    cyc(0, 1, 0, rnd128(), rnd128());
    cyc(1, 1, 1, rnd128(), rnd128());
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, rnd128(), rnd128());
    @(negedge clk);
    compare();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule